// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in the receive path of an Ethernet MAC and decides, frame by frame, whether a frame is meant for this station. It keeps a small table of station addresses, each with its own enable bit, and three global switches: exact-match compare, accept broadcast and accept multicast. As the first six bytes of a frame arrive, it collects the destination address. On the sixth byte it compares that address against every enabled table entry in parallel. It also tests the address for the all-ones broadcast pattern and for the group bit.

The decision reports accept or reject, whether a table entry matched, and the lowest matching entry index. It is registered on the clock edge that takes the sixth byte. It then stays constant until the next start-of-frame strobe. A simple write-only register port loads the table words, the enable mask and the control bits. Entry 0 is meant to hold the station's own address. The hardware treats it like any other entry.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, decValid, decAccept, decHit and decIndex are 0, and the table, enable mask and control bits are all 0. A frame received before any register write is therefore rejected.
- R2: Register map, byte offsets on regAddr (bits 1:0 ignored):
  - Entry k high word at 8k: address byte 0 in bits 31:24, byte 1 in 23:16, byte 2 in 15:8, byte 3 in 7:0.
  - Entry k low word at 8k+4: byte 4 in bits 31:24, byte 5 in 23:16. Bits 15:0 are ignored.
  - Enable mask at 8·ENTRIES: bit k enables entry k.
  - Control at 8·ENTRIES+4: bit 0 compare enable, bit 1 accept multicast, bit 2 accept broadcast.
- R3: With compare enable set, a frame whose destination equals an enabled entry k gives decAccept=1, decHit=1 and decIndex=k. When decHit is 0, decIndex reads 0.
- R4: An entry whose mask bit is 0 never matches. With compare enable clear, no entry matches.
- R5: When several enabled entries match, decIndex is the lowest matching index.
- R6: With accept broadcast set, a destination of all ones is accepted with decHit=0, unless a table entry also matches.
- R7: With accept multicast set, a destination whose group bit (bit 0 of address byte 0) is 1 is accepted, except the all-ones address, which only accept broadcast passes.
- R8: Any frame that meets none of R3, R6 and R7 is rejected: decAccept=0.
- R9: Timing of the decision:
  - decValid and the decision appear in the cycle after the clock edge that takes the sixth destination byte.
  - They stay constant while later bytes arrive.
  - rxSof clears decValid on the next edge.
  - Bytes seen before the first rxSof after reset are ignored.
- R10: Cycles with rxByteValid low between destination bytes do not change the collected address or the decision.
- R11: A register write in the same cycle as the sixth byte does not affect that frame's decision, which uses the table as it was before the write. The write takes effect for the next frame.
- R12: A byte presented together with rxSof is destination byte 0 of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register byte offset |
| regWrData | input | 32 | Register write data |
| rxSof | input | 1 | Start-of-frame strobe |
| rxByteValid | input | 1 | rxByte holds a frame byte this cycle |
| rxByte | input | 8 | Received frame byte |
| decValid | output | 1 | Decision available for current frame |
| decAccept | output | 1 | Frame accepted |
| decHit | output | 1 | A table entry matched |
| decIndex | output | IDX_W | Lowest matching entry index |

## Verification
Two things can land in the same cycle: a register write that reprograms an entry, and the sixth destination byte that triggers the comparison. The bench presents a frame that matches an entry and rewrites that entry's high word on the exact cycle of the last address byte. It expects the frame to be accepted against the old contents. It then resends the same frame and expects a rejection. Random frames mix exact copies of table entries, broadcast and group addresses, and byte gaps, with a table that is reprogrammed from time to time. A bench model of the table computes the expected decision for each frame.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int CTL_CMP    = 0;
  localparam int CTL_MCAST  = 1;
  localparam int CTL_BCAST  = 2;

  typedef struct packed {
    logic       capture;
    logic [2:0] byteIdx;
    logic       decide;
    logic       clearDec;
  } camStrobe_t;
endpackage

// File: rtl/cam_ctrl.sv
module cam_ctrl
  import addr_filter_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxSof,
  input  logic       rxByteValid,
  output camStrobe_t strb
);
  localparam logic [2:0] LAST_IDX = 3'(ADDR_BYTES - 1);
  localparam logic [2:0] DONE_CNT = 3'(ADDR_BYTES);

  logic       active;
  logic [2:0] byteCnt;

  always_comb begin
    strb.clearDec = rxSof;
    strb.byteIdx  = rxSof ? 3'd0 : byteCnt;
    strb.capture  = rxByteValid && (rxSof || (active && byteCnt < DONE_CNT));
    strb.decide   = strb.capture && (strb.byteIdx == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      byteCnt <= '0;
    end else if (rxSof) begin
      active  <= 1'b1;
      byteCnt <= rxByteValid ? 3'd1 : 3'd0;
    end else if (strb.capture) begin
      byteCnt <= byteCnt + 3'd1;
    end
  end

  // R9: the address counter never runs past the last destination byte
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= DONE_CNT);

  // R12: a byte that comes with the start strobe is byte 0
  a_r12_sof_first_byte: assert property (@(posedge clk) disable iff (!rstN)
    (rxSof && rxByteValid) |=> (byteCnt == 3'd1 && active));

  // R9: nothing is captured before the first start strobe
  a_r9_idle_ignores: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !rxSof) |-> !strb.capture);
endmodule

// File: rtl/cam_datapath.sv
module cam_datapath
  import addr_filter_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int REG_AW  = 8,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  camStrobe_t        strb,
  input  logic [7:0]        rxByte,
  output logic              decValid,
  output logic              decAccept,
  output logic              decHit,
  output logic [IDX_W-1:0]  decIndex
);
  localparam int WORD_W   = REG_AW - 2;
  localparam int MASK_WRD = 2 * ENTRIES;
  localparam int CTL_WRD  = 2 * ENTRIES + 1;

  logic [31:0]        entryHi [ENTRIES];
  logic [15:0]        entryLo [ENTRIES];
  logic [ENTRIES-1:0] enMask;
  logic [2:0]         ctlBits;
  logic [7:0]         addrByte [ADDR_BYTES-1];
  logic [WORD_W-1:0]  wordIdx;

  assign wordIdx = regAddr[REG_AW-1:2];

  // register file: all state written from one process
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < ENTRIES; k++) begin
        entryHi[k] <= '0;
        entryLo[k] <= '0;
      end
      enMask  <= '0;
      ctlBits <= '0;
    end else if (regWrEn) begin
      for (int k = 0; k < ENTRIES; k++) begin
        if (wordIdx == WORD_W'(2 * k))     entryHi[k] <= regWrData;
        if (wordIdx == WORD_W'(2 * k + 1)) entryLo[k] <= regWrData[31:16];
      end
      if (wordIdx == WORD_W'(MASK_WRD)) enMask  <= regWrData[ENTRIES-1:0];
      if (wordIdx == WORD_W'(CTL_WRD))  ctlBits <= regWrData[2:0];
    end
  end

  // destination byte collection (the last byte is used live)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < ADDR_BYTES - 1; b++) addrByte[b] <= '0;
    end else if (strb.capture && strb.byteIdx < 3'(ADDR_BYTES - 1)) begin
      addrByte[strb.byteIdx] <= rxByte;
    end
  end

  logic [47:0] cand;
  assign cand = {addrByte[0], addrByte[1], addrByte[2], addrByte[3], addrByte[4], rxByte};

  logic [ENTRIES-1:0] entryHit;
  for (genvar k = 0; k < ENTRIES; k++) begin : g_match
    assign entryHit[k] = enMask[k] && (entryHi[k] == cand[47:16]) && (entryLo[k] == cand[15:0]);
  end

  logic [IDX_W-1:0] hitIdx;
  always_comb begin
    hitIdx = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (entryHit[k]) hitIdx = IDX_W'(k);
    end
  end

  logic cmpHit, isBcast, isMcast, acceptNow;
  always_comb begin
    cmpHit    = ctlBits[CTL_CMP] && (|entryHit);
    isBcast   = &cand;
    isMcast   = cand[40] && !isBcast;
    acceptNow = cmpHit || (ctlBits[CTL_BCAST] && isBcast) || (ctlBits[CTL_MCAST] && isMcast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
      decHit    <= 1'b0;
      decIndex  <= '0;
    end else if (strb.clearDec) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
      decHit    <= 1'b0;
      decIndex  <= '0;
    end else if (strb.decide) begin
      decValid  <= 1'b1;
      decAccept <= acceptNow;
      decHit    <= cmpHit;
      decIndex  <= cmpHit ? hitIdx : '0;
    end
  end

  // R9: start strobe withdraws the previous decision
  a_r9_sof_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearDec |=> !decValid);

  // R9: a published decision holds until the next frame starts
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !strb.clearDec) |=> (decValid && $stable(decAccept) && $stable(decHit) && $stable(decIndex)));

  // R3: index reads zero when no entry matched
  a_r3_index_zero_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !decHit) |-> (decIndex == '0));

  // R6: a table hit always means acceptance
  a_r6_hit_accepts: assert property (@(posedge clk) disable iff (!rstN)
    decHit |-> (decAccept && decValid));

  // R4: a reported hit points at an entry that was enabled when judged
  a_r4_enabled_hit: assert property (@(posedge clk) disable iff (!rstN)
    strb.decide |=> (!decHit || ((($past(enMask) >> decIndex) & ENTRIES'(1)) != '0)));
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import addr_filter_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int REG_AW = $clog2(ENTRIES * 8 + 8),
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic              rxSof,
  input  logic              rxByteValid,
  input  logic [7:0]        rxByte,
  output logic              decValid,
  output logic              decAccept,
  output logic              decHit,
  output logic [IDX_W-1:0]  decIndex
);
  camStrobe_t strb;

  cam_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rxSof       (rxSof),
    .rxByteValid (rxByteValid),
    .strb        (strb)
  );

  cam_datapath #(
    .ENTRIES (ENTRIES),
    .REG_AW  (REG_AW),
    .IDX_W   (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb),
    .rxByte    (rxByte),
    .decValid  (decValid),
    .decAccept (decAccept),
    .decHit    (decHit),
    .decIndex  (decIndex)
  );
endmodule

// File: tb/dest_addr_filter_tb.sv
`timescale 1ns/1ps
module dest_addr_filter_tb;
  localparam int ENTRIES = 16;
  localparam int REG_AW  = $clog2(ENTRIES * 8 + 8);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int MASK_OFF = ENTRIES * 8;
  localparam int CTL_OFF  = ENTRIES * 8 + 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [REG_AW-1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic rxSof = 1'b0;
  logic rxByteValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic decValid, decAccept, decHit;
  logic [IDX_W-1:0] decIndex;

  always #2.5 clk = ~clk;

  dest_addr_filter #(.ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .rxSof(rxSof), .rxByteValid(rxByteValid), .rxByte(rxByte),
    .decValid(decValid), .decAccept(decAccept), .decHit(decHit), .decIndex(decIndex));

  int errors = 0;
  int checks = 0;
  logic [31:0] mHi [ENTRIES];
  logic [15:0] mLo [ENTRIES];
  logic [ENTRIES-1:0] mMask = '0;
  logic [2:0] mCtl = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void modelWr(input int off, input logic [31:0] d);
    int w = off / 4;
    if (w < 2 * ENTRIES) begin
      if (w % 2 == 0) mHi[w / 2] = d;
      else mLo[w / 2] = d[31:16];
    end else if (w == 2 * ENTRIES) mMask = d[ENTRIES-1:0];
    else if (w == 2 * ENTRIES + 1) mCtl = d[2:0];
  endfunction

  function automatic void model(input logic [47:0] d, output logic acc, output logic hit, output int idx);
    logic bc = (d == 48'hFFFF_FFFF_FFFF);
    logic mc = d[40] && !bc;
    hit = 1'b0;
    idx = 0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (!hit && mCtl[0] && mMask[k] && mHi[k] == d[47:16] && mLo[k] == d[15:0]) begin
        hit = 1'b1;
        idx = k;
      end
    end
    acc = hit || (mCtl[2] && bc) || (mCtl[1] && mc);
  endfunction

  task automatic regWr(input int off, input logic [31:0] d);
    regWrEn = 1'b1;
    regAddr = REG_AW'(off);
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    modelWr(off, d);
  endtask

  task automatic sendFrame(input string req, input logic [47:0] d, input bit gaps, input int extra,
                           input bit wrAtLast, input int wrOff, input logic [31:0] wrData);
    logic eAcc, eHit;
    int eIdx;
    for (int i = 0; i < 6; i++) begin
      if (gaps && i > 0) begin
        int g = $urandom_range(0, 2);
        rxByteValid = 1'b0;
        repeat (g) @(negedge clk);
      end
      rxSof = (i == 0);
      rxByteValid = 1'b1;
      rxByte = d[47 - 8 * i -: 8];
      if (i == 5) begin
        model(d, eAcc, eHit, eIdx);
        if (wrAtLast) begin
          regWrEn = 1'b1;
          regAddr = REG_AW'(wrOff);
          regWrData = wrData;
        end
      end
      @(negedge clk);
      rxSof = 1'b0;
      regWrEn = 1'b0;
      if (i == 5 && wrAtLast) modelWr(wrOff, wrData);
      if (i == 4) chk({req, " R9 early valid"}, 32'(decValid), 32'd0);
    end
    rxByteValid = 1'b0;
    chk({req, " valid"}, 32'(decValid), 32'd1);
    chk({req, " accept"}, 32'(decAccept), 32'(eAcc));
    chk({req, " hit"}, 32'(decHit), 32'(eHit));
    chk({req, " index"}, 32'(decIndex), 32'(eIdx));
    if (extra > 0) begin
      for (int e = 0; e < extra; e++) begin
        rxByteValid = 1'b1;
        rxByte = 8'($urandom);
        @(negedge clk);
      end
      rxByteValid = 1'b0;
      chk({req, " R9 hold accept"}, 32'(decAccept), 32'(eAcc));
      chk({req, " R9 hold index"}, 32'(decIndex), 32'(eIdx));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < ENTRIES; k++) begin
      mHi[k] = '0;
      mLo[k] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 decValid", 32'(decValid), 32'd0);
    chk("R1 decAccept", 32'(decAccept), 32'd0);
    chk("R1 decHit", 32'(decHit), 32'd0);
    chk("R1 decIndex", 32'(decIndex), 32'd0);
    // R1 / R8: empty table rejects everything, even broadcast
    sendFrame("R1", 48'hFFFF_FFFF_FFFF, 0, 0, 0, 0, 0);
    sendFrame("R8", 48'h0000_0000_0000, 0, 0, 0, 0, 0);
    // R9: bytes before a start strobe (after a finished frame) are ignored
    regWr(CTL_OFF, 32'h4);
    for (int i = 0; i < 8; i++) begin
      rxByteValid = 1'b1;
      rxByte = 8'hFF;
      @(negedge clk);
    end
    rxByteValid = 1'b0;
    chk("R9 bytes without sof keep old decision", 32'(decAccept), 32'd0);
    // R9: start strobe alone clears the decision
    rxSof = 1'b1;
    @(negedge clk);
    rxSof = 1'b0;
    chk("R9 sof clears valid", 32'(decValid), 32'd0);

    // R2 / R3: entry 0 programmed, low half of low word ignored
    regWr(0, 32'h0211_2233);
    regWr(4, 32'h4455_ABCD);
    regWr(MASK_OFF, 32'h1);
    regWr(CTL_OFF, 32'h1);
    sendFrame("R2 R3 exact match", 48'h0211_2233_4455, 0, 3, 0, 0, 0);
    chk("R3 direct accept", 32'(decAccept), 32'd1);
    sendFrame("R8 near miss", 48'h0211_2233_4456, 0, 0, 0, 0, 0);
    chk("R8 direct reject", 32'(decAccept), 32'd0);
    // R5 duplicate entries, lowest wins
    regWr(5 * 8, 32'h0A0B_0C0D);
    regWr(5 * 8 + 4, 32'h0E0F_0000);
    regWr(9 * 8, 32'h0A0B_0C0D);
    regWr(9 * 8 + 4, 32'h0E0F_0000);
    regWr(MASK_OFF, 32'h0221);
    sendFrame("R5 lowest index", 48'h0A0B_0C0D_0E0F, 0, 0, 0, 0, 0);
    chk("R5 direct index", 32'(decIndex), 32'd5);
    // R4 disabled entry skipped
    regWr(MASK_OFF, 32'h0201);
    sendFrame("R4 masked entry", 48'h0A0B_0C0D_0E0F, 1, 0, 0, 0, 0);
    chk("R4 direct index", 32'(decIndex), 32'd9);
    regWr(CTL_OFF, 32'h0);
    sendFrame("R4 compare off", 48'h0A0B_0C0D_0E0F, 0, 0, 0, 0, 0);
    chk("R4 direct reject", 32'(decAccept), 32'd0);
    // R6 / R7 broadcast and multicast
    regWr(CTL_OFF, 32'h4);
    sendFrame("R6 broadcast", 48'hFFFF_FFFF_FFFF, 0, 0, 0, 0, 0);
    chk("R6 direct accept", 32'(decAccept), 32'd1);
    regWr(CTL_OFF, 32'h2);
    sendFrame("R7 broadcast not multicast", 48'hFFFF_FFFF_FFFF, 0, 0, 0, 0, 0);
    chk("R7 direct bcast reject", 32'(decAccept), 32'd0);
    sendFrame("R7 group address", 48'h0100_5E00_0001, 0, 0, 0, 0, 0);
    chk("R7 direct accept", 32'(decAccept), 32'd1);
    regWr(CTL_OFF, 32'h0);
    sendFrame("R8 group rejected", 48'h0100_5E00_0001, 0, 0, 0, 0, 0);
    // R10 gaps
    regWr(CTL_OFF, 32'h1);
    sendFrame("R10 gapped bytes", 48'h0211_2233_4455, 1, 0, 0, 0, 0);
    chk("R10 direct accept", 32'(decAccept), 32'd1);
    // R11 write on the sixth byte
    regWr(3 * 8, 32'hC0FF_EE00);
    regWr(3 * 8 + 4, 32'h1234_0000);
    regWr(MASK_OFF, 32'h0009);
    sendFrame("R11 same-cycle write", 48'hC0FF_EE00_1234, 0, 0, 1, 3 * 8, 32'h0000_0000);
    chk("R11 old table used", 32'(decAccept), 32'd1);
    sendFrame("R11 write applies next frame", 48'hC0FF_EE00_1234, 0, 0, 0, 0, 0);
    chk("R11 new table used", 32'(decAccept), 32'd0);

    // random phase (R3 R4 R5 R6 R7 R8 R12)
    for (int f = 0; f < 400; f++) begin
      logic [47:0] d;
      int r;
      if (f % 25 == 0) begin
        for (int k = 0; k < ENTRIES; k++) begin
          regWr(8 * k, {24'h00AA_55, 8'($urandom_range(0, 3))});
          regWr(8 * k + 4, {8'($urandom_range(0, 3)), 8'h77, 16'($urandom)});
        end
        regWr(MASK_OFF, 32'($urandom));
        regWr(CTL_OFF, 32'($urandom_range(0, 7)));
      end
      r = $urandom_range(0, 9);
      if (r < 5) begin
        int k = $urandom_range(0, ENTRIES - 1);
        d = {mHi[k], mLo[k]};
      end else if (r == 5) d = 48'hFFFF_FFFF_FFFF;
      else begin
        d = {16'($urandom), 32'($urandom)};
        d[40] = (r < 8);
      end
      sendFrame("R12 random frame", d, bit'($urandom_range(0, 1)), $urandom_range(0, 2), 0, 0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule